// File: doc/BRIEF.md
# Packed Palette Store with Output Color Re-encoding

This block holds a color palette of up to 256 entries for a display pipeline. Software sees the palette as 128 32-bit words, and each word carries two 16-bit color entries. A word write stores the raw value, which can be read back unchanged. The same write also queues both entries for conversion into the output pixel format chosen by a static selector. The converted colors go into a second array, so the pixel path looks colors up by an 8-bit index and never does any arithmetic of its own.

Each raw entry has three 5-bit components. Each component is widened to 8 bits with zeros below, and the result is packed into one of four layouts: 3-3-2, 5-5-5, 5-6-5, or a full 8-8-8 layout that also serves 32-bit displays. The format is captured together with the data at the moment of the write. An entry therefore keeps the encoding it was written in until it is written again.

Top module: `palette_xlat`

## Requirements
- R1: After reset every raw word reads as zero and every lookup returns zero.
- R2: `rd_data` shows, in the same cycle and without a clock, the last value written to word `rd_addr`. All 32 bits are kept, including both intensity bits.
- R3: Word n carries entry 2n in bits [15:0] and entry 2n+1 in bits [31:16]. A lookup at index 2n decodes the low half and a lookup at index 2n+1 decodes the high half.
- R4: Within an entry, red is bits [4:0], green is bits [9:5] and blue is bits [14:10]. Bit 15 never affects the converted color.
- R5: Format code 0 (3-3-2) gives `lk_color` = {16'b0, red[4:2], green[4:2], blue[4:3]}.
- R6: Format code 1 (5-5-5) gives `lk_color` = {9'b0, red, green, blue}, with red in bits [14:10].
- R7: Format code 2 (5-6-5) gives `lk_color` = {8'b0, red, green, 1'b0, blue}.
- R8: Format code 3 (8-8-8, also used for 32-bit output) gives `lk_color` = {red, 3'b0, green, 3'b0, blue, 3'b0}.
- R9: `lk_color` is registered and shows the entry at `lk_idx` one edge after that index is sampled. A write taken at edge k changes the converted entries at edge k+1. A lookup sampled at edge k+1 still returns the old color, and a lookup sampled at edge k+2 returns the new one.
- R10: The format applied to an entry is the value of `fmt_sel` at its write edge. Changing `fmt_sel` later leaves entries that are already stored unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 2 | Output format code: 0 = 3-3-2, 1 = 5-5-5, 2 = 5-6-5, 3 = 8-8-8 |
| wr_en | input | 1 | Word write strobe |
| wr_addr | input | 7 | Word index of the write |
| wr_data | input | 32 | Two packed raw entries |
| rd_addr | input | 7 | Word index of the raw read |
| rd_data | output | 32 | Raw word at `rd_addr` |
| lk_idx | input | 8 | Entry index of the lookup |
| lk_color | output | 24 | Converted color, one cycle after the index |

## Verification
The hardest case to reach is a lookup that lands exactly between a write and the update of the converted array. From the ports, the stale and the fresh color differ only for one edge. A directed sequence therefore rewrites an entry and holds the lookup index on it across both edges, so the old color is checked first and the new color next. A second hard case is an entry that has kept its old encoding after the format selector moved on. The random phase changes `fmt_sel` between writes and tracks the format of each word, so many stored entries are read back in a format that differs from the current selector.

// File: rtl/palx_pkg.sv
package palx_pkg;

  typedef enum logic [1:0] {
    FMT_RGB332 = 2'd0,
    FMT_RGB555 = 2'd1,
    FMT_RGB565 = 2'd2,
    FMT_RGB888 = 2'd3
  } fmt_e;

  localparam int COMP_W  = 5;
  localparam int FIELD_W = 3 * COMP_W;   // used part of one entry
  localparam int COLOR_W = 24;

  // Widen each 5-bit component to 8 bits and pack it in the chosen layout.
  function automatic logic [COLOR_W-1:0] pack_color(logic [FIELD_W-1:0] e, fmt_e f);
    logic [7:0] r8, g8, b8;
    logic [COLOR_W-1:0] c;
    r8 = {e[4:0],   3'b000};
    g8 = {e[9:5],   3'b000};
    b8 = {e[14:10], 3'b000};
    case (f)
      FMT_RGB332: c = {16'd0, r8[7:5], g8[7:5], b8[7:6]};
      FMT_RGB555: c = {9'd0,  r8[7:3], g8[7:3], b8[7:3]};
      FMT_RGB565: c = {8'd0,  r8[7:3], g8[7:2], b8[7:3]};
      default:    c = {r8, g8, b8};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/palx_raw_store.sv
module palx_raw_store #(
  parameter int WORD_CNT = 128,
  parameter int WORD_W   = 32,
  localparam int AW      = $clog2(WORD_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data
);

  logic [WORD_W-1:0] raw_q [WORD_CNT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORD_CNT; i++) raw_q[i] <= '0;
    end else if (wr_en) begin
      raw_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = raw_q[rd_addr];

  // R2: a written word holds the written value one edge later
  p_raw_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> raw_q[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/palx_encoder.sv
module palx_encoder
  import palx_pkg::*;
(
  input  logic [FIELD_W-1:0] entry,
  input  fmt_e               fmt,
  output logic [COLOR_W-1:0] color
);

  assign color = pack_color(entry, fmt);

endmodule

// File: rtl/palx_conv_store.sv
module palx_conv_store
  import palx_pkg::*;
#(
  parameter int WORD_CNT = 128,
  localparam int AW      = $clog2(WORD_CNT),
  localparam int IW      = AW + 1,
  localparam int ENT_CNT = 2 * WORD_CNT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  fmt_e                 fmt,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [2*FIELD_W-1:0] wr_fields,   // {high entry, low entry}
  input  logic [IW-1:0]        lk_idx,
  output logic [COLOR_W-1:0]   lk_color
);

  // Staging register: the write is converted in the cycle after it lands.
  logic                 stg_vld;
  logic [AW-1:0]        stg_addr;
  logic [2*FIELD_W-1:0] stg_fields;
  fmt_e                 stg_fmt;
  logic [COLOR_W-1:0]   enc_out [2];
  logic [COLOR_W-1:0]   conv_q [ENT_CNT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_vld    <= 1'b0;
      stg_addr   <= '0;
      stg_fields <= '0;
      stg_fmt    <= FMT_RGB332;
    end else begin
      stg_vld    <= wr_en;
      stg_addr   <= wr_addr;
      stg_fields <= wr_fields;
      stg_fmt    <= fmt;
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    palx_encoder u_enc (
      .entry (stg_fields[h*FIELD_W +: FIELD_W]),
      .fmt   (stg_fmt),
      .color (enc_out[h])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENT_CNT; i++) conv_q[i] <= '0;
      lk_color <= '0;
    end else begin
      if (stg_vld) begin
        for (int h = 0; h < 2; h++) conv_q[{stg_addr, h[0]}] <= enc_out[h];
      end
      lk_color <= conv_q[lk_idx];
    end
  end

  // R3: the low half of a written word lands at the even entry two edges later
  p_conv_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ##1 conv_q[{$past(wr_addr, 2), 1'b0}] ==
      pack_color($past(wr_fields[FIELD_W-1:0], 2), $past(fmt, 2)));

  // R3: the high half lands at the odd entry
  p_conv_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ##1 conv_q[{$past(wr_addr, 2), 1'b1}] ==
      pack_color($past(wr_fields[2*FIELD_W-1:FIELD_W], 2), $past(fmt, 2)));

  // R9: lookup has exactly one cycle of latency
  p_lookup_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> lk_color == $past(conv_q[lk_idx]));

endmodule

// File: rtl/palette_xlat.sv
module palette_xlat
  import palx_pkg::*;
#(
  parameter int WORD_CNT = 128,
  localparam int WORD_W  = 32,
  localparam int AW      = $clog2(WORD_CNT),
  localparam int IW      = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        fmt_sel,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic [IW-1:0]     lk_idx,
  output logic [COLOR_W-1:0] lk_color
);

  // Intensity bits (15 and 31) are dropped before conversion (R4).
  logic [2*FIELD_W-1:0] wr_fields;
  assign wr_fields = {wr_data[30:16], wr_data[14:0]};

  palx_raw_store #(.WORD_CNT(WORD_CNT), .WORD_W(WORD_W)) u_raw (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  palx_conv_store #(.WORD_CNT(WORD_CNT)) u_conv (
    .clk       (clk),
    .rst_n     (rst_n),
    .fmt       (fmt_e'(fmt_sel)),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_fields (wr_fields),
    .lk_idx    (lk_idx),
    .lk_color  (lk_color)
  );

endmodule

// File: tb/palette_xlat_test.sv
`timescale 1ns/1ps
module palette_xlat_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt_sel = 2'd0;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [6:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [7:0]  lk_idx = '0;
  logic [23:0] lk_color;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_raw [128];
  logic [1:0]  m_fmt [128];

  always #2.5 clk = ~clk;

  palette_xlat uut (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .lk_idx(lk_idx), .lk_color(lk_color)
  );

  // Independent model of the conversion, written with integer shifts.
  function automatic logic [23:0] expect_color(logic [15:0] e, logic [1:0] f);
    int r, g, b;
    r = (int'(e) & 31) << 3;
    g = ((int'(e) >> 5) & 31) << 3;
    b = ((int'(e) >> 10) & 31) << 3;
    case (f)
      2'd0:    return 24'(((r >> 5) << 5) | ((g >> 5) << 2) | (b >> 6));
      2'd1:    return 24'(((r >> 3) << 10) | ((g >> 3) << 5) | (b >> 3));
      2'd2:    return 24'(((r >> 3) << 11) | ((g >> 2) << 5) | (b >> 3));
      default: return 24'((r << 16) | (g << 8) | b);
    endcase
  endfunction

  function automatic logic [23:0] model_lookup(logic [7:0] idx);
    logic [31:0] w;
    w = m_raw[idx[7:1]];
    return expect_color(idx[0] ? w[31:16] : w[15:0], m_fmt[idx[7:1]]);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    m_raw[a] = d;
    m_fmt[a] = fmt_sel;
  endtask

  task automatic rd_check(string req, logic [6:0] a);
    rd_addr = a;
    #1;
    check(req, rd_data, m_raw[a]);
  endtask

  // Waits one edge so a preceding write has reached the converted array.
  task automatic lk_check(string req, logic [7:0] idx);
    @(negedge clk);
    lk_idx = idx;
    @(negedge clk);
    check(req, {8'd0, lk_color}, {8'd0, model_lookup(idx)});
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin m_raw[i] = '0; m_fmt[i] = 2'd0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd_check("R1 raw zero", 7'd0);
    rd_check("R1 raw zero", 7'd127);
    lk_check("R1 lookup zero", 8'd0);
    lk_check("R1 lookup zero", 8'd255);

    // R3 R4 R8: known components in 8-8-8 mode, intensity bit set
    fmt_sel = 2'd3;
    wr(7'd5, {1'b1, 5'd3, 5'd10, 5'd31, 1'b1, 5'd1, 5'd2, 5'd4});
    rd_check("R2 raw readback keeps intensity bits", 7'd5);
    lk_check("R3 R8 low entry", 8'd10);
    check("R8 low value", {8'd0, lk_color}, 32'h20_10_08);
    lk_check("R3 R8 high entry", 8'd11);
    check("R8 high value", {8'd0, lk_color}, 32'hF8_50_18);
    // R4: flipping only bit 15 changes nothing converted
    wr(7'd5, {1'b0, 5'd3, 5'd10, 5'd31, 1'b0, 5'd1, 5'd2, 5'd4});
    lk_check("R4 intensity ignored", 8'd10);
    check("R4 intensity ignored value", {8'd0, lk_color}, 32'h20_10_08);

    // R5 R6 R7 with an all-ones entry and a mixed entry
    fmt_sel = 2'd0;
    wr(7'd6, 32'h7FFF_2D6B);
    lk_check("R5 3-3-2 mixed", 8'd12);
    lk_check("R5 3-3-2 full", 8'd13);
    check("R5 3-3-2 full value", {8'd0, lk_color}, 32'h0000_00FF);
    fmt_sel = 2'd1;
    wr(7'd7, 32'h7FFF_2D6B);
    lk_check("R6 5-5-5 mixed", 8'd14);
    lk_check("R6 5-5-5 full", 8'd15);
    check("R6 5-5-5 full value", {8'd0, lk_color}, 32'h0000_7FFF);
    fmt_sel = 2'd2;
    wr(7'd8, 32'h001F_03E0);
    lk_check("R7 5-6-5 green only", 8'd16);
    check("R7 5-6-5 green value", {8'd0, lk_color}, 32'h0000_07C0);
    lk_check("R7 5-6-5 red only", 8'd17);
    check("R7 5-6-5 red value", {8'd0, lk_color}, 32'h0000_F800);

    // R10: entry keeps format of its write after the selector moves
    fmt_sel = 2'd3;
    lk_check("R10 old format kept", 8'd16);
    check("R10 old format value", {8'd0, lk_color}, 32'h0000_07C0);

    // R9: update timing across the write edges
    wr(7'd9, 32'h0000_001F);                // entry 18 = red max, 8-8-8
    @(negedge clk);
    lk_idx = 8'd18;
    wr_en = 1'b1; wr_addr = 7'd9; wr_data = 32'h0000_7C00;  // write at edge k
    @(negedge clk);                          // edge k passed, lookup sampled old
    wr_en = 1'b0;
    check("R9 lookup before write", {8'd0, lk_color}, 32'hF8_00_00);
    @(negedge clk);                          // edge k+1: conv updates, lookup still old
    check("R9 lookup at k+1 old", {8'd0, lk_color}, 32'hF8_00_00);
    @(negedge clk);                          // edge k+2: new color visible
    check("R9 lookup at k+2 new", {8'd0, lk_color}, 32'h00_00_F8);
    m_raw[9] = 32'h0000_7C00; m_fmt[9] = 2'd3;

    // Random phase: R2 R3 R10 with shifting formats
    void'($urandom(32'd7));
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 9) == 0) fmt_sel = 2'($urandom_range(0, 3));
      wr(7'($urandom_range(0, 127)), $urandom());
      if (n % 4 == 0) begin
        rd_check("R2 random raw", 7'($urandom_range(0, 127)));
        lk_check("R3 R10 random lookup", 8'($urandom_range(0, 255)));
      end
    end
    for (int i = 0; i < 256; i++) lk_check("R3 R10 sweep", 8'(i));
    for (int i = 0; i < 128; i++) rd_check("R2 sweep", 7'(i));

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule